// File: doc/BRIEF.md
# Burst Transmit Handshake Controller

This block sequences one baseband transmit port through power-up, calibration and data bursts. Everything runs on a single master clock. When the power enable goes high, the block leaves sleep and waits for an external calibration-done pulse. It then raises a ready flag. A burst request taken while ready is high starts a burst. After a fixed latency, a divided bit clock is sent to the upstream data source.

The upstream source changes its serial data on the rising edge of the bit clock. The block samples that data on the falling edge and pairs the bits into two-bit symbols. The first bit of each pair is X and the second is Y. A one-cycle strobe marks each completed symbol.

The request is examined only when a symbol completes. Once the request is seen low, the block sends four more symbols, which is eight more bit clocks, and then returns to ready. A two-bit phase output tags each symbol as ramp-up, data or ramp-down. Downstream envelope logic uses this tag. Dropping the power enable at any time sends the block straight back to sleep.

Top module: `tx_burst_seq`

## Requirements
- R1: During reset and while the power enable is low, the outputs are sleep=1, ready=0, bclk=0 and phase=00.
- R2: An edge that samples the power enable high while asleep clears sleep. Ready stays low until an edge samples the calibration-done pulse high, and ready is high after that edge.
- R3: When an edge samples the burst request high while ready is high, ready is low after that same edge.
- R4: The bit clock is first high after the third edge that follows ready falling. It repeats every DIV master clocks and is high for the first DIV/2 of each period. It is low whenever no burst is running.
- R5: Serial data is sampled on the master edge where the bit clock falls. The first bit of each pair is placed on sym_x and the second on sym_y. sym_valid is high for exactly one cycle, with the new pair, after the second bit is sampled.
- R6: The burst request is tested each time a symbol completes. From the first completion that sees it low, four more symbols follow, so a burst of D data symbols makes 2*(D+4) bit-clock rising edges in total. Ready is high DIV/2 cycles after the last strobe.
- R7: phase is updated together with each strobe, using the codes 00 idle, 01 ramp-up, 10 data and 11 ramp-down. The first three symbols of a burst are 01 and the remaining data symbols are 10. The first three tail symbols are 11, and the fourth tail symbol and the time outside a burst are 00.
- R8: A burst request while ready is low has no effect: bclk stays low and ready keeps following calibration.
- R9: When an edge samples the power enable low, the block is asleep after that edge, with bclk=0, ready=0 and phase=00. Ready returns only after a new calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable level |
| burst_req | input | 1 | Burst request level |
| cal_done | input | 1 | Calibration complete pulse |
| sdata | input | 1 | Serial transmit data |
| ready | output | 1 | Burst may start |
| bclk | output | 1 | Gated bit clock to the data source |
| sym_x | output | 1 | First bit of the latest symbol |
| sym_y | output | 1 | Second bit of the latest symbol |
| sym_valid | output | 1 | One-cycle strobe for a new symbol |
| phase | output | 2 | Envelope phase tag |
| sleep | output | 1 | Sleep / output disable indicator |

## Verification
Bursts are swept with zero to five strobes seen before the request drops. This covers the case where the request falls during the first symbol, bursts shorter than the ramp-up, and bursts long enough to reach the data phase, so each shows a different mix of phase codes and a different tail count. Every burst carries its own bit pattern. This makes a swapped X/Y pair, a wrong sampling edge or an extra or missing symbol visible. Separate runs drive the request during calibration and remove power in the middle of a burst.

// File: rtl/tx_burst_seq.sv
module tx_burst_seq #(
  parameter int DIV      = 8,
  parameter int LAT_CYC  = 3,
  parameter int TAIL_SYM = 4,
  parameter int RAMP_SYM = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en,
  input  logic       burst_req,
  input  logic       cal_done,
  input  logic       sdata,
  output logic       ready,
  output logic       bclk,
  output logic       sym_x,
  output logic       sym_y,
  output logic       sym_valid,
  output logic [1:0] phase,
  output logic       sleep
);
  localparam int HALF = DIV / 2;
  localparam int DW   = $clog2(DIV);
  localparam int LW   = $clog2(LAT_CYC + 1);
  localparam int TW   = $clog2(TAIL_SYM + 1);
  localparam int RW   = $clog2(RAMP_SYM + 1);

  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_UP   = 2'b01;
  localparam logic [1:0] PH_DATA = 2'b10;
  localparam logic [1:0] PH_DOWN = 2'b11;

  typedef enum logic [2:0] {S_SLEEP, S_CAL, S_RDY, S_LAT, S_RUN, S_TAIL} st_t;

  st_t          st;
  logic [DW-1:0] dcnt;
  logic [LW-1:0] lcnt;
  logic [TW-1:0] tsym;
  logic [RW-1:0] rsym;
  logic          bitsel;
  logic          xbuf;

  wire busy    = (st == S_RUN) || (st == S_TAIL);
  wire capture = busy && (dcnt == DW'(HALF - 1));

  assign ready = (st == S_RDY);
  assign sleep = (st == S_SLEEP);
  assign bclk  = busy && (dcnt < DW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_SLEEP;
      dcnt      <= '0;
      lcnt      <= '0;
      tsym      <= '0;
      rsym      <= '0;
      bitsel    <= 1'b0;
      xbuf      <= 1'b0;
      sym_x     <= 1'b0;
      sym_y     <= 1'b0;
      sym_valid <= 1'b0;
      phase     <= PH_IDLE;
    end else begin
      sym_valid <= 1'b0;
      if (!pwr_en) begin
        st     <= S_SLEEP;
        dcnt   <= '0;
        bitsel <= 1'b0;
        phase  <= PH_IDLE;
      end else begin
        case (st)
          S_SLEEP: st <= S_CAL;
          S_CAL:   if (cal_done) st <= S_RDY;
          S_RDY:   if (burst_req) begin
                     st   <= S_LAT;
                     lcnt <= '0;
                   end
          S_LAT:   if (lcnt == LW'(LAT_CYC - 1)) begin
                     st     <= S_RUN;
                     dcnt   <= '0;
                     bitsel <= 1'b0;
                     rsym   <= '0;
                     phase  <= PH_IDLE;
                   end else begin
                     lcnt <= lcnt + 1'b1;
                   end
          default: begin
            dcnt <= (dcnt == DW'(DIV - 1)) ? '0 : dcnt + 1'b1;
            if (capture) begin
              if (!bitsel) begin
                xbuf   <= sdata;
                bitsel <= 1'b1;
              end else begin
                bitsel    <= 1'b0;
                sym_x     <= xbuf;
                sym_y     <= sdata;
                sym_valid <= 1'b1;
                if (st == S_RUN) begin
                  phase <= (rsym < RW'(RAMP_SYM)) ? PH_UP : PH_DATA;
                  if (rsym < RW'(RAMP_SYM)) rsym <= rsym + 1'b1;
                  if (!burst_req) begin
                    st   <= S_TAIL;
                    tsym <= '0;
                  end
                end else begin
                  phase <= (tsym < TW'(RAMP_SYM)) ? PH_DOWN : PH_IDLE;
                  tsym  <= tsym + 1'b1;
                end
              end
            end
            if (st == S_TAIL && dcnt == DW'(DIV - 1) && tsym == TW'(TAIL_SYM)) begin
              st    <= S_RDY;
              phase <= PH_IDLE;
            end
          end
        endcase
      end
    end
  end

  a_r3_ready_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && burst_req && pwr_en) |=> !ready);

  a_r2_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && pwr_en) |=> (!sleep && !ready));

  a_r4_bclk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || sleep) |-> !bclk);

  a_r5_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> !bclk);

  a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (sleep && !bclk && !ready && phase == 2'b00));
endmodule

// File: tb/tx_burst_seq_tb.sv
module tx_burst_seq_tb;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b0;
  logic burst_req = 1'b0;
  logic cal_done = 1'b0;
  logic sdata = 1'b0;
  logic ready, bclk, sym_x, sym_y, sym_valid, sleep;
  logic [1:0] phase;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_burst_seq #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .burst_req(burst_req),
    .cal_done(cal_done), .sdata(sdata), .ready(ready), .bclk(bclk),
    .sym_x(sym_x), .sym_y(sym_y), .sym_valid(sym_valid), .phase(phase),
    .sleep(sleep)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pat(input int k, input int i);
    return logic'(((i * (k + 3)) ^ (i >> 1) ^ k) & 1);
  endfunction

  task automatic power_up();
    pwr_en = 1'b1;
    @(negedge clk);
    chk(sleep == 1'b0, "R2 sleep cleared", int'(sleep), 0);
    repeat (5) @(negedge clk);
    chk(ready == 1'b0, "R2 no ready before calibration", int'(ready), 0);
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    chk(ready == 1'b1, "R2 ready after calibration", int'(ready), 1);
  endtask

  task automatic run_burst(input int k);
    int cyc = 0, j = 0, bi = 0, lat = 0, rises = 0, last_rise = 0, since = -1;
    int dsym = k + 1;
    int ep;
    bit first = 1, prev_b = 0, done = 0, per_ok = 1;
    burst_req = 1'b1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (first) begin
        chk(ready == 1'b0, "R3 ready falls", int'(ready), 0);
        first = 0;
        if (k == 0) burst_req = 1'b0;
      end
      if (bclk && !prev_b) begin
        if (rises == 0) chk(lat == 3, "R4 start latency", lat, 3);
        else if (cyc - last_rise != DIV) per_ok = 0;
        last_rise = cyc;
        rises++;
        sdata = pat(k, bi);
        bi++;
      end
      if (!bclk && prev_b && (cyc - last_rise) != HALF) per_ok = 0;
      if (rises == 0 && !bclk) lat++;
      prev_b = bclk;
      if (sym_valid) begin
        chk(sym_x == pat(k, 2 * j), "R5 sym_x", int'(sym_x), int'(pat(k, 2 * j)));
        chk(sym_y == pat(k, 2 * j + 1), "R5 sym_y", int'(sym_y), int'(pat(k, 2 * j + 1)));
        if (j < dsym) ep = (j < 3) ? 1 : 2;
        else ep = (j - dsym < 3) ? 3 : 0;
        chk(int'(phase) == ep, "R7 phase", int'(phase), ep);
        j++;
        if (k > 0 && j == k) burst_req = 1'b0;
        if (j == k + 5) since = 0;
      end else if (since >= 0) begin
        since++;
        if (ready) begin
          chk(since == HALF, "R6 ready return delay", since, HALF);
          done = 1;
        end
      end
    end
    chk(per_ok, "R4 bit clock period and duty", int'(per_ok), 1);
    chk(rises == 2 * (k + 5), "R6 bit clock count", rises, 2 * (k + 5));
    chk(j == k + 5, "R6 symbol count", j, k + 5);
    chk(done, "R6 ready returned", int'(done), 1);
    chk(phase == 2'b00 && !bclk, "R7 idle after burst", int'(phase), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sleep && !ready && !bclk && phase == 2'b00, "R1 reset state", int'(sleep), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sleep && !ready && !bclk && phase == 2'b00, "R1 asleep with power low", int'(sleep), 1);

    pwr_en = 1'b1;
    @(negedge clk);
    burst_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!bclk && !ready, "R8 request ignored while not ready", int'(bclk), 0);
    end
    burst_req = 1'b0;
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    chk(ready == 1'b1, "R8 ready after calibration", int'(ready), 1);
    @(negedge clk);
    chk(ready && !bclk, "R8 no burst started", int'(ready), 1);

    for (int k = 0; k <= 5; k++) begin
      run_burst(k);
      repeat (2) @(negedge clk);
    end

    burst_req = 1'b1;
    begin
      int s = 0;
      for (int c = 0; c < 400 && s < 3; c++) begin
        @(negedge clk);
        if (sym_valid) s++;
      end
      chk(s == 3, "R9 burst running before abort", s, 3);
    end
    pwr_en = 1'b0;
    @(negedge clk);
    chk(sleep && !bclk && !ready && phase == 2'b00, "R9 abort to sleep", int'(sleep), 1);
    burst_req = 1'b0;
    repeat (2) @(negedge clk);
    power_up();
    run_burst(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule